// File: doc/BRIEF.md
# Four-Stage Add Pipeline Core

This core runs a fixed program of register-to-register add instructions through four stages: fetch, operand read, add, and register write. Fetch takes one 16-bit instruction word per cycle from a program store that is set by a parameter. The program counter steps by two bytes every cycle and never stalls. When it passes the last word it wraps to address zero, so the program repeats for as long as the clock runs.

Each word holds an opcode byte and a register byte. The register byte selects two operands, and the second operand is also the destination. Operands are read from a sixteen-entry, 64-bit register file. The sum moves through two pipeline registers, together with its destination index, and is written at the end of the fourth cycle. There is no forwarding and no interlock. An instruction that sits one or two slots behind a writer reads the value from before that write. Any register can be read at any time on a combinational debug port.

Top module: `add_pipe_core`

## Requirements
- R1: After reset the program counter is 0. It advances by 2 on every clock edge, wrapping modulo 2*PROG_DEPTH, so word n of the program is fetched on edge n+1 and the program repeats.
- R2: Word layout: bits [15:8] are the opcode, [7:4] are rA and [3:0] are rB. Opcode 0x60 writes R[rA] + R[rB] into register rB.
- R3: Counting from the edge that fetches an instruction, its result appears on the debug port after the fourth edge. After the third edge the target still shows its previous value.
- R4: Once the pipeline is full, one instruction retires on every clock edge, including across the wrap of the program counter.
- R5: An instruction reads an operand written by the instruction three or more slots ahead of it with the new value. It reads the old value when the writer is one or two slots ahead.
- R6: An opcode other than 0x60 changes no register.
- R7: An add whose rB is 15 writes nothing. Register 15 keeps its value and can still be read as an operand.
- R8: While rst_ni is low, register i holds i*INIT_STEP, and the pipeline holds no valid instruction.
- R9: dbg_data_o shows, with no delay, the register selected by dbg_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_idx_i | input | 4 | Register index for the debug read |
| dbg_data_o | output | 64 | Value of the selected register |

## Verification
The test program covers several cases:
- Independent adds, which show the basic sum and the rate of one retirement per cycle.
- Reads of a register written one, two, three and five slots earlier. These separate the stale window from the point where the new value becomes visible.
- A non-add opcode and an add aimed at register 15. Both must leave their target unchanged, and register 15 is then used as a source.

The program is run three times through the wrap of the program counter, with values growing on each pass. Each result is read both one cycle before and in the cycle it is due, which pins the latency to exactly four cycles.

// File: rtl/add_core_pkg.sv
package add_core_pkg;
  localparam int          RIDX_W   = 4;
  localparam int          NUM_REGS = 1 << RIDX_W;
  localparam logic [7:0]  OP_ADD   = 8'h60;
  localparam logic [RIDX_W-1:0] REG_NONE = '1;

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef struct packed {
    logic [7:0] op;
    ridx_t      ra;
    ridx_t      rb;
  } instr_t;
endpackage

// File: rtl/add_fetch.sv
module add_fetch
  import add_core_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int PC_W = $clog2(PROG_DEPTH) + 1,
  parameter logic [16*PROG_DEPTH-1:0] PROG = '0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output instr_t fd_instr_o,
  output logic   fd_valid_o
);
  localparam int AW = PC_W - 1;

  logic [PC_W-1:0] pc_q;
  logic [AW-1:0]   word_addr;
  instr_t          imem_word;

  assign word_addr = pc_q[PC_W-1:1];
  assign imem_word = instr_t'(PROG[{word_addr, 4'b0000} +: 16]);

  // PC register doubles as the fetch/fetch stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      fd_instr_o <= '0;
      fd_valid_o <= 1'b0;
    end else begin
      pc_q       <= pc_q + PC_W'(2);
      fd_instr_o <= imem_word;
      fd_valid_o <= 1'b1;
    end
  end

  assert_pc_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_q == PC_W'($past(pc_q) + PC_W'(2)));
endmodule

// File: rtl/add_regfile.sv
module add_regfile
  import add_core_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] INIT_STEP = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ridx_t             raddr_a_i,
  input  ridx_t             raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  input  ridx_t             raddr_d_i,
  output logic [DATA_W-1:0] rdata_d_o,
  input  ridx_t             waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
  assign rdata_d_o = regs[raddr_d_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= DATA_W'(i) * INIT_STEP;
    end else if (waddr_i != REG_NONE) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assert_wr_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waddr_i != REG_NONE |=> regs[$past(waddr_i)] == $past(wdata_i));

  assert_none_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waddr_i == REG_NONE |=> $stable(regs[NUM_REGS-1]));
endmodule

// File: rtl/add_exec.sv
module add_exec
  import add_core_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  ridx_t             dst_i,
  output logic [DATA_W-1:0] sum_o,
  output ridx_t             dst_o
);
  // execute/writeback register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      dst_o <= REG_NONE;
    end else begin
      sum_o <= opa_i + opb_i;
      dst_o <= dst_i;
    end
  end
endmodule

// File: rtl/add_pipe_core.sv
module add_pipe_core
  import add_core_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PROG_DEPTH = 16,
  parameter logic [DATA_W-1:0] INIT_STEP = 100,
  parameter logic [16*PROG_DEPTH-1:0] PROG =
    {{(16*PROG_DEPTH-64){1'b0}}, 64'h6098_60CD_60AB_6089}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        dbg_idx_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  localparam int PC_W = $clog2(PROG_DEPTH) + 1;

  instr_t            fd_instr;
  logic              fd_valid;
  ridx_t             dec_dst;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic [DATA_W-1:0] de_a_q, de_b_q;
  ridx_t             de_dst_q;
  logic [DATA_W-1:0] ew_sum;
  ridx_t             ew_dst;

  add_fetch #(
    .PROG_DEPTH(PROG_DEPTH),
    .PC_W      (PC_W),
    .PROG      (PROG)
  ) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fd_instr_o(fd_instr),
    .fd_valid_o(fd_valid)
  );

  // decode: unknown opcodes retire as writes to the null index
  assign dec_dst = (fd_valid && fd_instr.op == OP_ADD) ? fd_instr.rb : REG_NONE;

  add_regfile #(
    .DATA_W   (DATA_W),
    .INIT_STEP(INIT_STEP)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raddr_a_i(fd_instr.ra),
    .raddr_b_i(fd_instr.rb),
    .rdata_a_o(rd_a),
    .rdata_b_o(rd_b),
    .raddr_d_i(dbg_idx_i),
    .rdata_d_o(dbg_data_o),
    .waddr_i  (ew_dst),
    .wdata_i  (ew_sum)
  );

  // decode/execute register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_a_q   <= '0;
      de_b_q   <= '0;
      de_dst_q <= REG_NONE;
    end else begin
      de_a_q   <= rd_a;
      de_b_q   <= rd_b;
      de_dst_q <= dec_dst;
    end
  end

  add_exec #(.DATA_W(DATA_W)) u_exec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .opa_i (de_a_q),
    .opb_i (de_b_q),
    .dst_i (de_dst_q),
    .sum_o (ew_sum),
    .dst_o (ew_dst)
  );

  assert_add_dest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fd_valid && fd_instr.op == OP_ADD) |-> ##2 ew_dst == $past(fd_instr.rb, 2));

  assert_nonadd_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fd_valid && fd_instr.op != OP_ADD) |-> ##2 ew_dst == REG_NONE);

  assert_sum_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ew_sum == $past(rd_a + rd_b, 2) || !$past(rst_ni, 2));
endmodule

// File: tb/add_pipe_core_test.sv
`timescale 1ns/1ps
module add_pipe_core_test;
  localparam int NRUN = 48;
  localparam int WD_CYCLES = 2000;
  localparam logic [255:0] TEST_PROG = {
    16'h603C, 16'h603A, 16'h603E, 16'h6033,
    16'h60F0, 16'h0000, 16'h6027, 16'h6016,
    16'h605F, 16'h1034, 16'h6021, 16'h6012,
    16'h6098, 16'h60CD, 16'h60AB, 16'h6089};

  typedef struct {
    int          at_edge;
    int          idx;
    logic [63:0] val;
    string       tag;
    int          instr;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  dbg_idx_i = '0;
  logic [63:0] dbg_data_o;

  int   n_chk = 0;
  int   n_bad = 0;
  int   edge_n = 0;
  exp_t sb[$];

  always #2.5 clk_i = ~clk_i;

  add_pipe_core #(.PROG(TEST_PROG)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dbg_idx_i (dbg_idx_i),
    .dbg_data_o(dbg_data_o)
  );

  task automatic check(input string tag, input int instr, input int idx,
                       input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s instr %0d reg %0d: got %0d expected %0d", tag, instr, idx, got, exp);
    end
  endtask

  task automatic push(input int e, input int idx, input logic [63:0] v,
                      input string tag, input int instr);
    exp_t it;
    it.at_edge = e; it.idx = idx; it.val = v; it.tag = tag; it.instr = instr;
    sb.push_back(it);
  endtask

  // driver: reference model of the stale-read pipeline, fills the scoreboard
  task automatic build_expect();
    logic [63:0] st_rd [16];
    logic [63:0] st_wr [16];
    logic [63:0] res [NRUN];
    int          dst_of [NRUN];
    for (int i = 0; i < 16; i++) begin
      st_rd[i] = 64'(i * 100);
      st_wr[i] = 64'(i * 100);
    end
    for (int j = 0; j < NRUN; j++) begin
      logic [15:0] w;
      int ra, rb;
      bit is_add, hz;
      string tag;
      w = TEST_PROG[(j % 16) * 16 +: 16];
      ra = int'(w[7:4]);
      rb = int'(w[3:0]);
      is_add = (w[15:8] == 8'h60);
      if (j >= 3 && dst_of[j-3] != 15) st_rd[dst_of[j-3]] = res[j-3];
      res[j] = st_rd[ra] + st_rd[rb];
      dst_of[j] = (is_add && rb != 15) ? rb : 15;
      hz = 1'b0;
      for (int d = 1; d <= 3; d++)
        if (j >= d && dst_of[j-d] != 15 && (dst_of[j-d] == ra || dst_of[j-d] == rb)) hz = 1'b1;
      if (!is_add)      tag = "R6";
      else if (rb == 15) tag = "R7";
      else if (hz)       tag = "R5";
      else if (j >= 16)  tag = "R4";
      else               tag = "R2";
      push(j + 3, rb, st_wr[rb], "R3", j);   // R3: not yet visible
      if (dst_of[j] != 15) st_wr[rb] = res[j];
      push(j + 4, rb, st_wr[rb], tag, j);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni) begin
        edge_n++;
        #1;
        while (sb.size() > 0 && sb[0].at_edge == edge_n) begin
          exp_t it;
          it = sb.pop_front();
          dbg_idx_i = 4'(it.idx);
          #0.2;
          check(it.tag, it.instr, it.idx, dbg_data_o, it.val);
        end
      end
    end
  end

  initial begin
    build_expect();
    #10;
    for (int i = 0; i < 16; i++) begin
      dbg_idx_i = 4'(i);
      #0.2;
      check("R8", -1, i, dbg_data_o, 64'(i * 100));   // R8 and R9
    end
    #(21.0 - 13.2);
    rst_ni = 1'b1;
    fork
      begin
        wait (sb.size() == 0);
        repeat (2) @(posedge clk_i);
      end
      begin
        repeat (WD_CYCLES) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog: got %0d pending expected 0", sb.size());
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule